// File: doc/BRIEF.md
# Controller Code-Image Download Port

This block loads a byte-wide program into the code RAM of an embedded controller through a single 32-bit host register. Each host write carries three fields at once: a control byte in the top byte, a data byte in bits 23:16, and a byte address in the low half. When the control byte holds the upload value 0x0F, the data byte is stored at the given address. The controller stays in reset while uploading, and a control byte with bit 28 set releases it.

Each host read returns the current control byte, the code RAM byte at the internal pointer, and the pointer itself. The pointer then advances by one. An upload write also moves the pointer to the written address. The host can therefore read back each write straight away to confirm the byte. It can also write address 0 and sweep the whole image by repeated reads. The controller core fetches code through a separate asynchronous read port.

Top module: `fw_dl_port`

## Requirements
- R1: After rst_ni is released, ctrl_rst_o is 1, rdata_o is 0 and the internal pointer is 0.
- R2: A write whose bits 31:24 equal 0x0F stores bits 23:16 into code RAM. The address is bits 13:0, taken modulo the RAM depth. Bits 15:14 are ignored. The write also sets the pointer to that 14-bit address.
- R3: A write whose control byte is not 0x0F leaves code RAM and the pointer unchanged. The control byte is still updated.
- R4: A read updates rdata_o on the next clock edge to {control byte, RAM byte at pointer, 2'b00, pointer}, using the state before that edge. The pointer then increments. rdata_o holds its value when there is no read.
- R5: The 14-bit pointer wraps from 0x3FFF to 0x0000.
- R6: A read that directly follows an upload write returns the written word with bits 15:14 cleared.
- R7: ctrl_rst_o is set by an upload (0x0F) write. It is cleared only by a write with bit 28 set, such as control 0x13. A write with control 0x03 leaves it as it was.
- R8: When a read and a write share a cycle, the read returns the state from before the write. An upload write then sets the pointer to its address without incrementing it. A non-upload write leaves the pointer incrementing as usual.
- R9: cpu_data_o combinationally returns the code RAM byte at cpu_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host register write strobe |
| rd_en_i | input | 1 | Host register read strobe |
| wdata_i | input | 32 | Host write word: control, data byte, address |
| rdata_o | output | 32 | Registered readback word |
| ctrl_rst_o | output | 1 | Reset to the embedded controller |
| cpu_addr_i | input | RAM_AW | Controller fetch address |
| cpu_data_o | output | 8 | Controller fetch data |

## Verification
A host read and a host write can land in the same cycle. This is the case where the readback path and the pointer-load path compete for the pointer. The bench drives both strobes together in two cases: with an upload write to a new address, and with a non-upload write. In each case it checks that the returned word reflects the state before the write. It then issues a following read to show whether the pointer was loaded from the write (upload case) or incremented (non-upload case).

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PTR_W    = 14;
  localparam int unsigned FIELD_W  = 16;
  localparam logic [7:0]  CTL_LOAD = 8'h0F;
  localparam int unsigned RUN_BIT  = 28;
endpackage

// File: rtl/fwdl_ctrl.sv
module fwdl_ctrl
  import fwdl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   ctl_o,
  output logic [PTR_W-1:0]    ptr_o,
  output logic                run_rst_o,
  output logic                ram_we_o,
  output logic [PTR_W-1:0]    ram_waddr_o,
  output logic [BYTE_W-1:0]   ram_wdata_o
);
  logic [BYTE_W-1:0] ctl_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rst_q;
  logic              load_wr;
  logic              unused_addr_hi;

  assign load_wr        = wr_en_i && (wdata_i[31:24] == CTL_LOAD);
  assign unused_addr_hi = ^wdata_i[15:PTR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      ptr_q <= '0;
      rst_q <= 1'b1;
    end else begin
      if (wr_en_i) ctl_q <= wdata_i[31:24];
      // write-side pointer load wins over read increment
      if (load_wr)      ptr_q <= wdata_i[PTR_W-1:0];
      else if (rd_en_i) ptr_q <= ptr_q + 1'b1;
      if (wr_en_i && wdata_i[RUN_BIT]) rst_q <= 1'b0;
      else if (load_wr)                rst_q <= 1'b1;
    end
  end

  assign ctl_o       = ctl_q;
  assign ptr_o       = ptr_q;
  assign run_rst_o   = rst_q;
  assign ram_we_o    = load_wr;
  assign ram_waddr_o = wdata_i[PTR_W-1:0];
  assign ram_wdata_o = wdata_i[23:16];
endmodule

// File: rtl/fwdl_code_ram.sv
module fwdl_code_ram
  import fwdl_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [BYTE_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [BYTE_W-1:0] rdata_b_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/fwdl_rdback.sv
module fwdl_rdback
  import fwdl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] ctl_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = FIELD_W - PTR_W;

  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= {ctl_i, byte_i, {PAD_W{1'b0}}, ptr_i};
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fw_dl_port.sv
module fw_dl_port
  import fwdl_pkg::*;
#(
  parameter int unsigned RAM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ctrl_rst_o,
  input  logic [RAM_AW-1:0] cpu_addr_i,
  output logic [7:0]        cpu_data_o
);
  logic [BYTE_W-1:0] ctl_w;
  logic [PTR_W-1:0]  ptr_w;
  logic              ram_we_w;
  logic [PTR_W-1:0]  ram_waddr_w;
  logic [BYTE_W-1:0] ram_wdata_w;
  logic [BYTE_W-1:0] rd_byte_w;

  fwdl_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .wdata_i     (wdata_i),
    .ctl_o       (ctl_w),
    .ptr_o       (ptr_w),
    .run_rst_o   (ctrl_rst_o),
    .ram_we_o    (ram_we_w),
    .ram_waddr_o (ram_waddr_w),
    .ram_wdata_o (ram_wdata_w)
  );

  fwdl_code_ram #(.AW(RAM_AW)) u_ram (
    .clk_i     (clk_i),
    .we_i      (ram_we_w),
    .waddr_i   (ram_waddr_w[RAM_AW-1:0]),
    .wdata_i   (ram_wdata_w),
    .raddr_a_i (ptr_w[RAM_AW-1:0]),
    .rdata_a_o (rd_byte_w),
    .raddr_b_i (cpu_addr_i),
    .rdata_b_o (cpu_data_o)
  );

  fwdl_rdback u_rdback (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .ctl_i   (ctl_w),
    .byte_i  (rd_byte_w),
    .ptr_i   (ptr_w),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/fwdl_checker.sv
module fwdl_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        ctrl_rst_o,
  input logic [13:0] ptr_i
);
  AST_RUN_NEEDS_BIT28: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_rst_o) |-> $past(wr_en_i && wdata_i[28])); // R7

  AST_HALT_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_rst_o) |-> $past(wr_en_i && wdata_i[31:24] == 8'h0F)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rdata_o)); // R4

  AST_RDATA_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i) |-> rdata_o[15:0] == {2'b00, $past(ptr_i)}); // R4

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && !(wr_en_i && wdata_i[31:24] == 8'h0F))
      |-> ptr_i == 14'($past(ptr_i) + 14'd1)); // R5

  AST_PTR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_en_i && !(wr_en_i && wdata_i[31:24] == 8'h0F)) |-> $stable(ptr_i)); // R3
endmodule

bind fw_dl_port fwdl_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ctrl_rst_o (ctrl_rst_o),
  .ptr_i      (ptr_w)
);

// File: tb/fw_dl_port_test.sv
module fw_dl_port_test;
  localparam int AW = 10;
  localparam int NV = 11;
  // {wr, rd, wdata, check, expected rdata}
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h0F110003, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h0FAA0000, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h0FBB0001, 1'b0, 32'h0},
    {1'b1, 1'b0, 32'h0FCC0002, 1'b0, 32'h0},
    {1'b0, 1'b1, 32'h0,        1'b1, 32'h0FCC0002},
    {1'b0, 1'b1, 32'h0,        1'b1, 32'h0F110003},
    {1'b1, 1'b0, 32'h0FAAC000, 1'b0, 32'h0},
    {1'b0, 1'b1, 32'h0,        1'b1, 32'h0FAA0000},
    {1'b1, 1'b0, 32'h03550001, 1'b0, 32'h0},
    {1'b0, 1'b1, 32'h0,        1'b1, 32'h03BB0001},
    {1'b0, 1'b1, 32'h0,        1'b1, 32'h03CC0002}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          crst;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_data;
  int            errors = 0;
  int            checks = 0;

  always #4 clk = ~clk;

  fw_dl_port #(.RAM_AW(AW)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .ctrl_rst_o (crst),
    .cpu_addr_i (cpu_addr),
    .cpu_data_o (cpu_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; wdata = d;
    @(posedge clk);
    #2;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 ctrl_rst", {31'b0, crst}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][66], VEC[i][65], VEC[i][64:33]);
      if (VEC[i][32]) chk($sformatf("R2/R3/R6 vec%0d", i), rdata, VEC[i][31:0]);
    end
    chk("R7 0x03 keeps reset", {31'b0, crst}, 32'h1);

    // R4 hold without read
    cyc(1'b0, 1'b0, 32'h0);
    chk("R4 hold", rdata, 32'h03CC0002);

    // R7 release and re-hold
    cyc(1'b1, 1'b0, 32'h13000003);
    chk("R7 release", {31'b0, crst}, 32'h0);
    cyc(1'b1, 1'b0, 32'h03000000);
    chk("R7 stays run", {31'b0, crst}, 32'h0);
    cyc(1'b1, 1'b0, 32'h0F773FFF);
    chk("R7 load halts", {31'b0, crst}, 32'h1);

    // R5 wrap
    cyc(1'b0, 1'b1, 32'h0);
    chk("R5 top addr", rdata, 32'h0F773FFF);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R5 wrap", rdata, 32'h0FAA0000);

    // R8 same-cycle read and upload write (pointer at 1)
    cyc(1'b1, 1'b1, 32'h0F120005);
    chk("R8 pre-write read", rdata, 32'h0FBB0001);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R8 pointer loaded", rdata, 32'h0F120005);

    // R8 same-cycle read and non-upload write
    cyc(1'b1, 1'b0, 32'h0F560007);
    cyc(1'b1, 1'b0, 32'h0F340006);
    cyc(1'b1, 1'b1, 32'h03000000);
    chk("R8 pre-write ctrl", rdata, 32'h0F340006);
    cyc(1'b0, 1'b1, 32'h0);
    chk("R8 pointer stepped", rdata, 32'h03560007);

    // R9 controller fetch port
    @(negedge clk); cpu_addr = 10'd1; #1;
    chk("R9 addr1", {24'b0, cpu_data}, 32'hBB);
    cpu_addr = 10'd3; #1;
    chk("R9 addr3", {24'b0, cpu_data}, 32'h11);
    cpu_addr = 10'h3FF; #1;
    chk("R9 aliased top", {24'b0, cpu_data}, 32'h77);

    // R1 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async rdata", rdata, 32'h0);
    chk("R1 async ctrl_rst", {31'b0, crst}, 32'h1);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b1, 32'h0);
    chk("R1 pointer zero", rdata, 32'h00AA0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule